// File: doc/BRIEF.md
# Synchronous SRAM Port with Selectable Read Latency

This block is one clocked access port onto a small static memory. On each rising clock edge it samples an address, a pair of select inputs, a write strobe and four active-low byte masks. The memory word is 36 bits wide, split into four 9-bit lanes. A static strap, `pipe_mode`, sets when read data appears. With the strap low, read data flows straight from the array in the cycle after the sampling edge. With the strap high, it passes through one more register and appears a cycle later.

The output bus is modelled as a data vector plus one drive flag per lane, in place of real tristate pins. Select and byte-mask decisions are registered and travel with the data, so the drive flags switch in step with it in both modes. The active-low output enable is not clocked: it gates the drive flags combinationally. An address strobe decides whether a new address is taken on an edge. While the strobe is high, the address already held is used again.

Top module: `sram_sync_port`

## Requirements
- R1: While `out_en_n` is high, every bit of `lane_drv` is 0 and `rdata` is 0, with no clock edge needed. While it is low, the registered lane enables reach `lane_drv` unchanged.
- R2: With `pipe_mode` = 1, a selected read sampled at rising edge k drives its data and lane flags only after edge k+1. Between edges k and k+1 the output still shows the slot sampled at edge k-1.
- R3: With `pipe_mode` = 0, a selected read sampled at rising edge k drives its data and lane flags between edges k and k+1.
- R4: While `addr_load_n` is low, a new address is taken on every edge. Back-to-back reads in any address order each return their own word.
- R5: The port is selected only when `sel_lo_n` = 0 and `sel_hi` = 1. Any other combination leaves all lanes undriven in that slot, with the same latency as read data, and writes nothing.
- R6: On a selected read, lane i (bits 9i+8 down to 9i) is driven only if `byte_mask_n[i]` was 0 when the address was sampled. The flags follow the same latency as the data.
- R7: A selected sample with `write_n` = 0 stores `wdata` lane i into the addressed word for each lane with `byte_mask_n[i]` = 0. Lanes whose mask is 1 keep their old contents. The slot of a write drives no lane.
- R8: A read sampled on the edge right after a write to the same address returns the newly written lanes.
- R9: While `addr_load_n` is high at an edge, the address registered earlier is held and used for that read or write. Address loading does not depend on select.
- R10: During reset, `lane_drv` and `rdata` are 0, and the held address is cleared to 0.
- R11: Any lane of `rdata` whose `lane_drv` bit is 0 reads as all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pipe_mode | input | 1 | Static strap: 1 pipelined, 0 flow-through |
| addr_load_n | input | 1 | Active-low address load strobe |
| addr | input | AW (6) | Word address |
| sel_lo_n | input | 1 | Select, must be low to select |
| sel_hi | input | 1 | Select, must be high to select |
| write_n | input | 1 | Low = write, high = read |
| byte_mask_n | input | 4 | Active-low per-lane enables |
| wdata | input | 36 | Write data |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 36 | Read data, undriven lanes zero |
| lane_drv | output | 4 | Per-lane drive flag (tristate model) |

## Verification
Each scenario runs once with the strap low and once with it high. The same slot stream must then show a one-slot shift, which separates the two latency paths. Streams of reads in scrambled address order show that the address is reloaded every edge. Streams that keep the strobe high show that the old address is held. Walking through the four select combinations and several byte-mask patterns shows that the disable decisions are registered and aligned with the data, not applied at once. Masked writes, a write while deselected, and a read on the edge right after a write separate correct lane merging and write ordering from stale or over-written data. Toggling the output enable in the middle of a cycle checks the one unclocked path.

// File: rtl/sram_port_pkg.sv
package sram_port_pkg;

  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } rd_mode_e;

  // Decoded command for one sampled slot
  typedef struct packed {
    logic sel;
    logic rd;
  } slot_cmd_t;

endpackage

// File: rtl/sram_cmd_reg.sv
module sram_cmd_reg
  import sram_port_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_load_n,
  input  logic [AW-1:0]    addr,
  input  logic             sel_lo_n,
  input  logic             sel_hi,
  input  logic             write_n,
  input  logic [LANES-1:0] byte_mask_n,
  output logic [AW-1:0]    cur_addr,
  output logic [LANES-1:0] wr_lanes,
  output logic [AW-1:0]    addr_q,
  output logic [LANES-1:0] rd_lanes_q
);

  slot_cmd_t        cmd;
  logic [AW-1:0]    addr_d;
  logic [LANES-1:0] rd_lanes_d;

  always_comb begin
    cmd.sel    = ~sel_lo_n & sel_hi;
    cmd.rd     = write_n;
    addr_d     = addr_load_n ? addr_q : addr;
    cur_addr   = addr_d;
    wr_lanes   = {LANES{cmd.sel & ~cmd.rd}} & ~byte_mask_n;
    rd_lanes_d = {LANES{cmd.sel & cmd.rd}} & ~byte_mask_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      rd_lanes_q <= '0;
    end else begin
      addr_q     <= addr_d;
      rd_lanes_q <= rd_lanes_d;
    end
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) begin
        mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_port_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] ft_data,
  input  logic [LANES-1:0]        ft_drv,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_drv
);

  localparam int DW = LANES * LANE_W;

  rd_mode_e         mode;
  logic [DW-1:0]    data_q, data_d, data_sel;
  logic [LANES-1:0] drv_q, drv_d, drv_sel;

  always_comb begin
    mode     = rd_mode_e'(pipe_mode);
    data_d   = (mode == MODE_PIPE) ? ft_data : data_q;
    drv_d    = (mode == MODE_PIPE) ? ft_drv  : drv_q;
    data_sel = (mode == MODE_PIPE) ? data_q  : ft_data;
    drv_sel  = (mode == MODE_PIPE) ? drv_q   : ft_drv;
    lane_drv = drv_sel & {LANES{~out_en_n}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      drv_q  <= '0;
    end else begin
      data_q <= data_d;
      drv_q  <= drv_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_gate
    assign rdata[g*LANE_W +: LANE_W] = data_sel[g*LANE_W +: LANE_W] & {LANE_W{lane_drv[g]}};
  end

endmodule

// File: rtl/sram_sync_port.sv
module sram_sync_port #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    addr_load_n,
  input  logic [AW-1:0]           addr,
  input  logic                    sel_lo_n,
  input  logic                    sel_hi,
  input  logic                    write_n,
  input  logic [LANES-1:0]        byte_mask_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_drv
);

  localparam int DW = LANES * LANE_W;

  logic [AW-1:0]    cur_addr;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] wr_lanes;
  logic [LANES-1:0] rd_lanes_q;
  logic [DW-1:0]    arr_data;

  sram_cmd_reg #(.AW(AW), .LANES(LANES)) u_cmd (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_load_n (addr_load_n),
    .addr        (addr),
    .sel_lo_n    (sel_lo_n),
    .sel_hi      (sel_hi),
    .write_n     (write_n),
    .byte_mask_n (byte_mask_n),
    .cur_addr    (cur_addr),
    .wr_lanes    (wr_lanes),
    .addr_q      (addr_q),
    .rd_lanes_q  (rd_lanes_q)
  );

  sram_lane_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk      (clk),
    .wr_lanes (wr_lanes),
    .wr_addr  (cur_addr),
    .wdata    (wdata),
    .rd_addr  (addr_q),
    .rd_data  (arr_data)
  );

  sram_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .out_en_n  (out_en_n),
    .ft_data   (arr_data),
    .ft_drv    (rd_lanes_q),
    .rdata     (rdata),
    .lane_drv  (lane_drv)
  );

endmodule

// File: rtl/sram_sync_port_chk.sv
module sram_sync_port_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pipe_mode,
  input logic                    sel_lo_n,
  input logic                    sel_hi,
  input logic                    write_n,
  input logic [LANES-1:0]        byte_mask_n,
  input logic                    out_en_n,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic [LANES-1:0]        lane_drv
);

  localparam int DW = LANES * LANE_W;

  logic          sel_in;
  logic [DW-1:0] drv_mask;

  always_comb begin
    sel_in = ~sel_lo_n & sel_hi;
    for (int l = 0; l < LANES; l++) begin
      drv_mask[l*LANE_W +: LANE_W] = {LANE_W{lane_drv[l]}};
    end
  end

  assert_oe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (lane_drv == '0));

  assert_pipe_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && sel_in && write_n) |=> ##1 (out_en_n || lane_drv == ~$past(byte_mask_n, 2)));

  assert_flow_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && sel_in && write_n) |=> (out_en_n || lane_drv == ~$past(byte_mask_n)));

  assert_flow_desel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !sel_in) |=> (lane_drv == '0));

  assert_pipe_desel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && !sel_in) |=> ##1 (lane_drv == '0));

  assert_flow_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && sel_in && write_n) |=> ((lane_drv & $past(byte_mask_n)) == '0));

  assert_pipe_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && sel_in && write_n) |=> ##1 ((lane_drv & $past(byte_mask_n, 2)) == '0));

  assert_write_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && sel_in && !write_n) |=> (lane_drv == '0));

  assert_undriven_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & ~drv_mask) == '0));

endmodule

bind sram_sync_port sram_sync_port_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pipe_mode   (pipe_mode),
  .sel_lo_n    (sel_lo_n),
  .sel_hi      (sel_hi),
  .write_n     (write_n),
  .byte_mask_n (byte_mask_n),
  .out_en_n    (out_en_n),
  .rdata       (rdata),
  .lane_drv    (lane_drv)
);

// File: tb/sram_sync_port_tb.sv
module sram_sync_port_tb;

  localparam int AW     = 6;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;
  localparam int DEPTH  = 1 << AW;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             pipe_mode;
  logic             addr_load_n;
  logic [AW-1:0]    addr;
  logic             sel_lo_n;
  logic             sel_hi;
  logic             write_n;
  logic [LANES-1:0] byte_mask_n;
  logic [DW-1:0]    wdata;
  logic             out_en_n;
  logic [DW-1:0]    rdata;
  logic [LANES-1:0] lane_drv;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [AW-1:0] hold_addr;

  // stream slot description
  logic [AW-1:0]    s_addr [8];
  logic [LANES-1:0] s_mask [8];
  logic             s_ld_n [8];
  logic             s_lo_n [8];
  logic             s_hi   [8];
  logic [LANES-1:0] e_drv  [8];
  logic [DW-1:0]    e_data [8];

  always #10 clk = ~clk;

  sram_sync_port #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pipe_mode   (pipe_mode),
    .addr_load_n (addr_load_n),
    .addr        (addr),
    .sel_lo_n    (sel_lo_n),
    .sel_hi      (sel_hi),
    .write_n     (write_n),
    .byte_mask_n (byte_mask_n),
    .wdata       (wdata),
    .out_en_n    (out_en_n),
    .rdata       (rdata),
    .lane_drv    (lane_drv)
  );

  function automatic logic [DW-1:0] lanes_to_mask(logic [LANES-1:0] d);
    logic [DW-1:0] m;
    for (int l = 0; l < LANES; l++) m[l*LANE_W +: LANE_W] = {LANE_W{d[l]}};
    return m;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_out(string req, logic [LANES-1:0] edrv, logic [DW-1:0] edata);
    chk(lane_drv == edrv, req, "lane_drv", DW'(lane_drv), DW'(edrv));
    chk(rdata == edata, req, "rdata", rdata, edata);
  endtask

  task automatic set_idle();
    sel_lo_n    = 1'b1;
    sel_hi      = 1'b0;
    addr_load_n = 1'b1;
    write_n     = 1'b1;
    byte_mask_n = '1;
    addr        = '0;
    wdata       = '0;
  endtask

  task automatic do_reset(bit mode);
    rst_n     = 1'b0;
    pipe_mode = mode;
    out_en_n  = 1'b0;
    set_idle();
    repeat (3) @(negedge clk);
    check_out("R10", '0, '0);
    rst_n     = 1'b1;
    hold_addr = '0;
  endtask

  task automatic write_word(logic [AW-1:0] a, logic [DW-1:0] d, logic [LANES-1:0] m, bit sel);
    @(negedge clk);
    addr_load_n = 1'b0;
    addr        = a;
    sel_lo_n    = ~sel;
    sel_hi      = 1'b1;
    write_n     = 1'b0;
    byte_mask_n = m;
    wdata       = d;
    hold_addr   = a;
    if (sel) begin
      for (int l = 0; l < LANES; l++)
        if (!m[l]) ref_mem[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
    end
    @(negedge clk);
    check_out("R7", '0, '0);
    set_idle();
  endtask

  task automatic slot(int i, logic [AW-1:0] a, logic [LANES-1:0] m, logic ld_n, logic lo_n, logic hi);
    s_addr[i] = a;
    s_mask[i] = m;
    s_ld_n[i] = ld_n;
    s_lo_n[i] = lo_n;
    s_hi[i]   = hi;
  endtask

  // Runs n read slots back to back; checks every output window including idle ones
  task automatic run_stream(int n, string req);
    int lat;
    lat = pipe_mode ? 1 : 0;
    for (int j = 0; j < n + lat + 2; j++) begin
      int k;
      @(negedge clk);
      k = j - 1 - lat;
      if (k >= 0 && k < n) check_out(req, e_drv[k], e_data[k]);
      else check_out(req, '0, '0);
      if (j < n) begin
        addr_load_n = s_ld_n[j];
        addr        = s_addr[j];
        sel_lo_n    = s_lo_n[j];
        sel_hi      = s_hi[j];
        write_n     = 1'b1;
        byte_mask_n = s_mask[j];
        if (!s_ld_n[j]) hold_addr = s_addr[j];
        e_drv[j]  = (!s_lo_n[j] && s_hi[j]) ? ~s_mask[j] : '0;
        e_data[j] = ref_mem[hold_addr] & lanes_to_mask(e_drv[j]);
      end else begin
        set_idle();
      end
    end
  endtask

  task automatic t_basic();
    write_word(6'd5,  36'h1_2345_6789, 4'b0000, 1'b1);
    write_word(6'd17, 36'hA_BCDE_F012, 4'b0000, 1'b1);
    write_word(6'd42, 36'h5_5AA5_5AA5, 4'b0000, 1'b1);
    write_word(6'd63, 36'hF_0F0F_0F0F, 4'b0000, 1'b1);
    slot(0, 6'd63, 4'b0000, 1'b0, 1'b0, 1'b1);
    slot(1, 6'd5,  4'b0000, 1'b0, 1'b0, 1'b1);
    slot(2, 6'd42, 4'b0000, 1'b0, 1'b0, 1'b1);
    slot(3, 6'd17, 4'b0000, 1'b0, 1'b0, 1'b1);
    run_stream(4, pipe_mode ? "R2 R4" : "R3 R4");
  endtask

  task automatic t_masked_write();
    write_word(6'd9, 36'h0_0000_0000, 4'b0000, 1'b1);
    write_word(6'd9, 36'hF_FFFF_FFFF, 4'b1010, 1'b1);
    write_word(6'd9, 36'h1_1111_1111, 4'b1110, 1'b1);
    slot(0, 6'd9, 4'b0000, 1'b0, 1'b0, 1'b1);
    run_stream(1, "R7");
  endtask

  task automatic t_read_after_write();
    @(negedge clk);
    addr_load_n = 1'b0;
    addr        = 6'd30;
    sel_lo_n    = 1'b0;
    sel_hi      = 1'b1;
    write_n     = 1'b0;
    byte_mask_n = 4'b0000;
    wdata       = 36'h9_8765_4321;
    ref_mem[6'd30] = 36'h9_8765_4321;
    hold_addr   = 6'd30;
    @(negedge clk);
    write_n     = 1'b1;
    if (pipe_mode) begin
      @(negedge clk);
      set_idle();
    end
    @(negedge clk);
    check_out("R8", '1, 36'h9_8765_4321);
    set_idle();
    @(negedge clk);
  endtask

  task automatic t_mask_read();
    slot(0, 6'd5,  4'b0110, 1'b0, 1'b0, 1'b1);
    slot(1, 6'd17, 4'b1111, 1'b0, 1'b0, 1'b1);
    slot(2, 6'd42, 4'b1110, 1'b0, 1'b0, 1'b1);
    slot(3, 6'd63, 4'b0101, 1'b0, 1'b0, 1'b1);
    run_stream(4, "R6 R11");
  endtask

  task automatic t_deselect();
    slot(0, 6'd5,  4'b0000, 1'b0, 1'b1, 1'b0);
    slot(1, 6'd17, 4'b0000, 1'b0, 1'b0, 1'b0);
    slot(2, 6'd42, 4'b0000, 1'b0, 1'b1, 1'b1);
    slot(3, 6'd63, 4'b0000, 1'b0, 1'b0, 1'b1);
    slot(4, 6'd5,  4'b0000, 1'b0, 1'b1, 1'b1);
    run_stream(5, "R5");
    write_word(6'd42, 36'h0_DEAD_BEEF, 4'b0000, 1'b0);
    slot(0, 6'd42, 4'b0000, 1'b0, 1'b0, 1'b1);
    run_stream(1, "R5 no write");
  endtask

  task automatic t_hold();
    slot(0, 6'd5,  4'b0000, 1'b0, 1'b0, 1'b1);
    slot(1, 6'd42, 4'b0000, 1'b1, 1'b0, 1'b1);
    slot(2, 6'd17, 4'b0011, 1'b1, 1'b0, 1'b1);
    slot(3, 6'd17, 4'b0000, 1'b0, 1'b0, 1'b1);
    run_stream(4, "R9");
    write_word(6'd63, 36'h3_3333_3333, 4'b0000, 1'b1);
    @(negedge clk);
    addr_load_n = 1'b1;
    addr        = 6'd0;
    sel_lo_n    = 1'b0;
    sel_hi      = 1'b1;
    write_n     = 1'b0;
    byte_mask_n = 4'b1100;
    wdata       = 36'h0_0000_0000;
    ref_mem[hold_addr][2*LANE_W-1:0] = '0;
    @(negedge clk);
    set_idle();
    slot(0, 6'd63, 4'b0000, 1'b0, 1'b0, 1'b1);
    slot(1, 6'd0,  4'b0000, 1'b0, 1'b0, 1'b1);
    run_stream(2, "R9 held write");
  endtask

  task automatic t_oe();
    @(negedge clk);
    addr_load_n = 1'b0;
    addr        = 6'd17;
    sel_lo_n    = 1'b0;
    sel_hi      = 1'b1;
    write_n     = 1'b1;
    byte_mask_n = 4'b0000;
    hold_addr   = 6'd17;
    @(negedge clk);
    if (pipe_mode) begin
      set_idle();
      @(negedge clk);
    end
    check_out("R1 on", '1, ref_mem[17]);
    out_en_n = 1'b1;
    #2;
    check_out("R1 off", '0, '0);
    out_en_n = 1'b0;
    #2;
    check_out("R1 back", '1, ref_mem[17]);
    set_idle();
    @(negedge clk);
  endtask

  task automatic run_mode(bit mode);
    do_reset(mode);
    t_basic();
    t_masked_write();
    t_read_after_write();
    t_mask_read();
    t_deselect();
    t_hold();
    t_oe();
  endtask

  initial begin
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule